// File: doc/BRIEF.md
# Serial Discrete-Input Status and Termination Configuration Slave

This block is the serial slave side of a discrete-input monitor. A host reaches it over a four-wire SPI-compatible link: an active-low select, a serial clock, serial data in and serial data out. A fifth pin, the mode line, is sampled when the select goes low. It picks one of two transfer kinds: a status read, which returns a snapshot of eight discrete inputs, or a configuration write, which loads an 8-bit termination register. The register sets, for each input, whether its pull-up or its pull-down switch is enabled.

The block runs in the system clock domain and oversamples the link pins through synchronizers. It uses one shift path for every transfer. The status snapshot is loaded into that path when the select falls, and each data-in bit enters behind the snapshot. Because of this, a second device placed in a chain receives the upstream stream eight clocks late, and two devices can be read in one 16-clock cycle. After reset, both enables of every input stay inactive, so each input sits in high impedance. This holds until the first complete configuration write has been accepted.

The link pins are control-rate signals, well below the system clock, and carry no handshake. There is no valid/ready flow at this edge: the host owns the serial clock and the block never stalls it. The serial output is given as a value and a separate drive-enable, so that the pad can be tri-stated outside a transfer.

Top module: `spi_di_slave`

## Requirements
- R1: After reset, `pu_en` and `pd_en` are all zero and `sdo_oe` is zero.
- R2: `sdo_oe` is 1 while `cs_n` is low (after the synchronizer delay) and 0 while it is high.
- R3: When `cs_n` falls, `din` is captured. `sdo` shows `din[7]` before the first rising `sclk` edge, then `din[6]` down to `din[0]`, moving on after each falling `sclk` edge.
- R4: The `sdi` bit sampled at rising edge k appears on `sdo` during serial bit k+8. In a 16-clock transfer, `sdo` carries the 8 status bits followed by the first 8 `sdi` bits.
- R5: `sel` is sampled when `cs_n` falls: 1 means configuration write, 0 means status read. A status read of 8 or more clocks leaves the configuration unchanged.
- R6: When `cs_n` rises after a write of exactly 8 clocks, the 8 `sdi` bits become the configuration, with the first bit received landing in bit 7.
- R7: A write of fewer than 8 clocks changes neither the configuration nor the high-impedance state.
- R8: Before the first accepted write, `pu_en` and `pd_en` are all zero. After it, for each bit i, `pu_en[i]` equals configuration bit i and `pd_en[i]` equals its inverse.
- R9: A write of more than 8 clocks keeps only the last 8 bits received.
- R10: Changes to `din` or `sel` after `cs_n` has fallen do not affect the bits shifted out or the transfer kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Active-low chip select |
| sel | input | 1 | Transfer kind, sampled at select fall (1 write, 0 read) |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in, sampled on rising sclk |
| sdo | output | 1 | Serial data out, changes after falling sclk |
| sdo_oe | output | 1 | Drive enable for the sdo pad |
| din | input | 8 | Discrete input status, bit 7 sent first |
| pu_en | output | 8 | Per-input pull-up enable |
| pd_en | output | 8 | Per-input pull-down enable |

## Verification
The bench aims at the load moment and the chain delay. A design that shifts before loading, or loads late, would send a bit other than `din[7]` first. A delay line that is off by one stage would put the chained `sdi` bits one clock early or late in the upper half of a 16-clock read. On the configuration path, it runs short writes both before and after the first accepted write, an over-long write, and a read. A design that counts badly would leave high impedance too early or would load a truncated value. A design that samples `sel` or `din` late would turn a read into a write, or would shift out a changed snapshot, when those pins move in the middle of a transfer.

// File: rtl/spi_di_pkg.sv
package spi_di_pkg;
  typedef enum logic {
    XFER_READ  = 1'b0,
    XFER_WRITE = 1'b1
  } xfer_kind_e;
endpackage

// File: rtl/spi_di_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
module spi_di_sync #(
  parameter int          N       = 1,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_di_edge.sv
// Edge detection on the synchronized select and serial clock.
module spi_di_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic sclk_s,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_rise,
  output logic sclk_fall
);
  logic cs_n_p, sclk_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_p <= 1'b1;
      sclk_p <= 1'b0;
    end else begin
      cs_n_p <= cs_n_s;
      sclk_p <= sclk_s;
    end
  end

  assign cs_fall   = cs_n_p & ~cs_n_s;
  assign cs_rise   = ~cs_n_p & cs_n_s;
  assign sclk_rise = sclk_s & ~sclk_p & ~cs_n_s & ~cs_fall;
  assign sclk_fall = ~sclk_s & sclk_p & ~cs_n_s & ~cs_fall;
endmodule

// File: rtl/spi_di_shift.sv
// Shared shift path: status snapshot out, pass-through delay, write capture.
module spi_di_shift
  import spi_di_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_fall,
  input  logic         cs_rise,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic         sel_s,
  input  logic         sdi_s,
  input  logic [W-1:0] din_s,
  output logic         sdo_bit,
  output logic         commit,
  output logic [W-1:0] commit_data
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  xfer_kind_e     kind;
  logic [W-1:0]   tx_q;
  logic [W-1:0]   rx_q;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind <= XFER_READ;
      cnt  <= '0;
    end else if (cs_fall) begin
      kind <= xfer_kind_e'(sel_s);
      cnt  <= '0;
    end else if (sclk_rise && cnt != FULL) begin
      cnt <= cnt + 1'b1;
    end
  end

  // receive path: sampled on rising serial clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_q <= '0;
    else if (sclk_rise) rx_q <= {rx_q[W-2:0], sdi_s};
  end

  // transmit path: loaded at select fall, advanced on falling serial clock;
  // the newest received bit enters behind the snapshot (W-bit delay)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_q <= '0;
    else if (cs_fall)   tx_q <= din_s;
    else if (sclk_fall) tx_q <= {tx_q[W-2:0], rx_q[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit      <= 1'b0;
      commit_data <= '0;
    end else begin
      commit <= cs_rise && (kind == XFER_WRITE) && (cnt == FULL);
      if (cs_rise) commit_data <= rx_q;
    end
  end

  assign sdo_bit = tx_q[W-1];

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  a_r6_commit_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(cs_rise));
endmodule

// File: rtl/spi_di_term.sv
// Termination register and per-input enable outputs.
module spi_di_term #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  logic [W-1:0] commit_data,
  output logic [W-1:0] pu_en,
  output logic [W-1:0] pd_en
);
  logic [W-1:0] cfg_q;
  logic         cfg_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cfg_valid <= 1'b0;
    end else if (commit) begin
      cfg_q     <= commit_data;
      cfg_valid <= 1'b1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_term
    always_comb begin
      pu_en[i] = cfg_valid &  cfg_q[i];
      pd_en[i] = cfg_valid & ~cfg_q[i];
    end
  end

  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_valid);
  a_r7_first_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> $past(commit));
  a_r6_cfg_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cfg_q));
endmodule

// File: rtl/spi_di_slave.sv
module spi_di_slave #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sel,
  input  logic         sclk,
  input  logic         sdi,
  output logic         sdo,
  output logic         sdo_oe,
  input  logic [W-1:0] din,
  output logic [W-1:0] pu_en,
  output logic [W-1:0] pd_en
);
  localparam int NPIN = 4;

  logic [NPIN-1:0] pins_s;
  logic [W-1:0]    din_s;
  logic cs_n_s, sel_s, sclk_s, sdi_s;
  logic cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic commit;
  logic [W-1:0] commit_data;

  spi_di_sync #(.N(NPIN), .STAGES(STAGES), .RST_VAL(NPIN'(4'b1000))) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sel, sclk, sdi}), .q(pins_s)
  );
  assign {cs_n_s, sel_s, sclk_s, sdi_s} = pins_s;

  spi_di_sync #(.N(W), .STAGES(STAGES), .RST_VAL('0)) u_din_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(din_s)
  );

  spi_di_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_s(sclk_s),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  spi_di_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sel_s(sel_s), .sdi_s(sdi_s), .din_s(din_s),
    .sdo_bit(sdo), .commit(commit), .commit_data(commit_data)
  );

  spi_di_term #(.W(W)) u_term (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_data(commit_data),
    .pu_en(pu_en), .pd_en(pd_en)
  );

  assign sdo_oe = ~cs_n_s;

  a_r2_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |=> $stable(sdo));
endmodule

// File: tb/spi_di_slave_test.sv
module spi_di_slave_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [7:0] din = 8'h00;
  logic sdo, sdo_oe;
  logic [7:0] pu_en, pd_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic  exp_q[$];
  string req_q[$];

  logic       m_valid = 1'b0;
  logic [7:0] m_cfg   = 8'h00;

  always #2.5 clk = ~clk;

  spi_di_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sel(sel), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .din(din), .pu_en(pu_en), .pd_en(pd_en)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_term(input string req);
    logic [7:0] epu, epd;
    epu = m_valid ? m_cfg : 8'h00;
    epd = m_valid ? ~m_cfg : 8'h00;
    check(pu_en === epu && pd_en === epd, req, {pu_en, pd_en}, {epu, epd});
  endtask

  // monitor: compares sdo at each rising serial clock
  initial begin
    forever begin
      @(posedge sclk);
      #1;
      if (exp_q.size() > 0) begin
        logic  e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(sdo === e && sdo_oe === 1'b1, r, {14'd0, sdo_oe, sdo}, {14'd0, 1'b1, e});
      end
    end
  end

  // driver: pushes expected sdo stream, runs one transfer, updates config model
  task automatic xfer(input logic selv, input logic [15:0] mosi, input int n,
                      input logic [7:0] dinv, input bit flip,
                      input string rbits, input string rterm);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(i < 8 ? dinv[7-i] : mosi[n-1-(i-8)]);
      req_q.push_back(rbits);
    end
    din = dinv;
    sel = selv;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(HALF);
    if (flip) begin
      sel = ~selv;
      din = ~dinv;
    end
    for (int i = 0; i < n; i++) begin
      sdi = mosi[n-1-i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    if (selv && n >= 8) begin
      m_valid = 1'b1;
      m_cfg   = mosi[7:0];
    end
    wait_clk(2 * HALF);
    check(sdo_oe === 1'b0, "R2", {15'd0, sdo_oe}, 16'd0);
    check(exp_q.size() == 0, rbits, 16'(exp_q.size()), 16'd0);
    chk_term(rterm);
  endtask

  initial begin
    wait_clk(200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1: reset state
    check(pu_en === 8'h00 && pd_en === 8'h00, "R1", {pu_en, pd_en}, 16'h0000);
    check(sdo_oe === 1'b0, "R1", {15'd0, sdo_oe}, 16'd0);
    // R3 read, R5 read leaves config alone
    xfer(1'b0, 16'h00FF, 8, 8'hA5, 1'b0, "R3", "R5");
    // R7 short write before first commit keeps high impedance
    xfer(1'b1, 16'h001F, 5, 8'h3C, 1'b0, "R3", "R7");
    // R6 full write, R8 enables follow config
    xfer(1'b1, 16'h003C, 8, 8'h81, 1'b0, "R3", "R6");
    chk_term("R8");
    // R4 daisy chain read, 16 clocks
    xfer(1'b0, 16'hC35A, 16, 8'h96, 1'b0, "R4", "R5");
    xfer(1'b0, 16'h6E21, 16, 8'h0F, 1'b0, "R4", "R5");
    // R10 sel and din change mid transfer are ignored
    xfer(1'b0, 16'h00E7, 8, 8'h5A, 1'b1, "R10", "R10");
    // R9 long write keeps last 8 bits
    xfer(1'b1, 16'h0ABC, 12, 8'h12, 1'b0, "R4", "R9");
    // R7 short write after commit keeps config
    xfer(1'b1, 16'h0005, 3, 8'hF0, 1'b0, "R3", "R7");
    // R6 write with mid-transfer sel change stays a write
    xfer(1'b1, 16'h00D2, 8, 8'h77, 1'b1, "R10", "R6");
    chk_term("R8");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule